// File: doc/BRIEF.md
# Breakpoint and Trace Trigger Unit

This unit sits beside a processor core and compares its stream of executed-instruction addresses and its stream of data-access addresses against a small bank of programmable breakpoint slots on every cycle. Each slot holds a compare address, a choice of which stream it watches, and an action. When a slot matches, it can request a halt, switch trace capture on or off, or only count the event. Slots can also be chained, so that a slot is live only after a chosen earlier slot has fired. This allows multi-stage triggers such as "trace from A, but halt at B only if A was seen first".

A debug command decoder configures the unit through a simple register write/read port. The observation port carries a valid bit per stream and has no ready signal: the unit accepts whatever the core presents, every cycle, and never applies back-pressure, so it cannot stall or alter the pipeline. The halt request, trace enable and per-slot hit flags are registered outputs. The trace enable gates an external trace store, and the hit flags feed a status bus. A separate debug-reset input clears the trigger state and resumes the core without losing configuration or counts.

Top module: `bpt_unit`

## Requirements
- R1: After reset, `halt_req`, `trace_en` and `bp_hit` are 0, and every register reads back as 0.
- R2: Register address `cfg_addr` = {global bit [7], slot index [6:3], field [2:0]}. For a slot, field 0 is the compare address, field 1 is control and field 2 is the hit counter. With the global bit set, field 0 is the enable mask (bit i enables slot i). Control layout: [1:0] action, [2] stream select, [7:4] chain predecessor index, [8] chain enable. A write takes effect at the clock edge on which `cfg_we` is high. `cfg_rdata` shows the register at `cfg_addr` combinationally.
- R3: A slot whose mask bit is 0 never fires: it sets no hit flag, takes no action and does not count.
- R4: A slot with stream select 0 matches only a valid instruction address equal to its compare value. With stream select 1 it matches only a valid data address. The hit flag `bp_hit[i]` is high in the cycle after the matching observation.
- R5: Action 00 (halt) sets `halt_req` in the cycle after the match. `halt_req` then stays high until a debug reset.
- R6: Action 01 sets `trace_en` and action 10 clears it, one cycle after the match. `trace_en` holds otherwise. If a start and a stop fire in the same cycle, trace ends up off.
- R7: Action 11 only counts: it changes neither `halt_req` nor `trace_en`.
- R8: When a halt and a trace start fire in the same cycle, `halt_req` is set and `trace_en` also updates in that same cycle.
- R9: A slot with chain enable set fires only if its predecessor slot has fired in an earlier cycle since the last debug reset. A predecessor index beyond the last slot never arms it.
- R10: `dbg_reset` clears `halt_req`, `trace_en` and all chain arm state at the next edge. This overrides any same-cycle action. Configuration and counters are kept.
- R11: Each slot has a 16-bit hit counter that increments on each firing and saturates at 0xFFFF. A write to its field 2 clears it, and a clear wins over a same-cycle hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dbg_reset | input | 1 | Synchronous clear of halt, trace and chain arm state |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register address {global, slot, field} |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` |
| ia_valid | input | 1 | Instruction address valid this cycle |
| ia_addr | input | ADDR_W | Executed instruction address |
| da_valid | input | 1 | Data access address valid this cycle |
| da_addr | input | ADDR_W | Data access address |
| halt_req | output | 1 | Sticky halt request to the core |
| trace_en | output | 1 | Trace capture enable |
| bp_hit | output | NUM_BP | Per-slot hit flags, one cycle after the match |

## Verification
Wrong internal state shows at the ports within one cycle of the next relevant observation. A stale mask or compare register gives a missing or spurious `bp_hit` bit on the cycle after the address is presented. Lost or stuck chain arm state shows as a chained slot that fires before its predecessor, or that still fires after a debug reset. A mis-ordered action merge shows up as a wrong `trace_en` level on the cycle after a simultaneous start and stop, or after a halt combined with a trace start. Counter faults stay hidden until the counter is read back, so the counts are read after known hit sequences, after a clear that collides with a hit, and after a run long enough to saturate.

// File: rtl/bpt_pkg.sv
package bpt_pkg;
  localparam int CFG_AW = 8;
  localparam int CFG_DW = 32;
  localparam int MAX_BP = 16;

  localparam logic [2:0] FLD_CMP  = 3'd0;
  localparam logic [2:0] FLD_CTRL = 3'd1;
  localparam logic [2:0] FLD_CNT  = 3'd2;
  localparam logic [2:0] FLD_MASK = 3'd0;

  typedef enum logic [1:0] {
    ACT_HALT   = 2'b00,
    ACT_TSTART = 2'b01,
    ACT_TSTOP  = 2'b10,
    ACT_COUNT  = 2'b11
  } bpt_act_e;

  typedef struct packed {
    logic       chain_en;
    logic [3:0] pred;
    logic       dsel;
    bpt_act_e   act;
  } bpt_ctrl_t;
endpackage

// File: rtl/bpt_slot.sv
module bpt_slot import bpt_pkg::*; #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_we,
  input  logic              ctrl_we,
  input  logic [ADDR_W-1:0] cmp_wd,
  input  bpt_ctrl_t         ctrl_wd,
  input  logic              ia_valid,
  input  logic [ADDR_W-1:0] ia_addr,
  input  logic              da_valid,
  input  logic [ADDR_W-1:0] da_addr,
  output logic [ADDR_W-1:0] cmp_q,
  output bpt_ctrl_t         ctrl_q,
  output logic              match
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q  <= '0;
      ctrl_q <= '0;
    end else begin
      if (cmp_we)  cmp_q  <= cmp_wd;
      if (ctrl_we) ctrl_q <= ctrl_wd;
    end
  end

  // stream select picks the watched bus; valid gates the compare
  assign match = ctrl_q.dsel ? (da_valid && (da_addr == cmp_q))
                             : (ia_valid && (ia_addr == cmp_q));
endmodule

// File: rtl/bpt_sat_cnt.sv
module bpt_sat_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (clr)               cnt <= '0;
    else if (inc && !(&cnt))    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/bpt_action.sv
module bpt_action import bpt_pkg::*; #(
  parameter int NUM_BP = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   dbg_reset,
  input  logic [NUM_BP-1:0]      fire,
  input  logic [NUM_BP-1:0][1:0] act,
  output logic                   halt_req,
  output logic                   trace_en
);
  logic any_halt, any_start, any_stop;

  always_comb begin
    any_halt  = 1'b0;
    any_start = 1'b0;
    any_stop  = 1'b0;
    for (int i = 0; i < NUM_BP; i++) begin
      if (fire[i]) begin
        case (bpt_act_e'(act[i]))
          ACT_HALT:   any_halt  = 1'b1;
          ACT_TSTART: any_start = 1'b1;
          ACT_TSTOP:  any_stop  = 1'b1;
          default:    ;
        endcase
      end
    end
  end

  // halt and trace update independently; stop beats start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_req <= 1'b0;
      trace_en <= 1'b0;
    end else if (dbg_reset) begin
      halt_req <= 1'b0;
      trace_en <= 1'b0;
    end else begin
      if (any_halt)       halt_req <= 1'b1;
      if (any_stop)       trace_en <= 1'b0;
      else if (any_start) trace_en <= 1'b1;
    end
  end
endmodule

// File: rtl/bpt_unit.sv
module bpt_unit import bpt_pkg::*; #(
  parameter int NUM_BP = 4,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbg_reset,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  output logic [CFG_DW-1:0] cfg_rdata,
  input  logic              ia_valid,
  input  logic [ADDR_W-1:0] ia_addr,
  input  logic              da_valid,
  input  logic [ADDR_W-1:0] da_addr,
  output logic              halt_req,
  output logic              trace_en,
  output logic [NUM_BP-1:0] bp_hit
);
  logic       glob;
  logic [3:0] idx;
  logic [2:0] fld;
  assign glob = cfg_addr[7];
  assign idx  = cfg_addr[6:3];
  assign fld  = cfg_addr[2:0];

  bpt_ctrl_t ctrl_wd;
  assign ctrl_wd = '{chain_en: cfg_wdata[8], pred: cfg_wdata[7:4],
                     dsel: cfg_wdata[2], act: bpt_act_e'(cfg_wdata[1:0])};

  logic [NUM_BP-1:0]      mask_q, armed_q, hit_q, fire, chain_on, raw_match;
  logic [MAX_BP-1:0]      armed_x;
  logic [4*NUM_BP-1:0]    pred_flat;
  logic [NUM_BP-1:0][1:0] act_v;
  logic [ADDR_W-1:0]      cmp_q [NUM_BP];
  logic [CNT_W-1:0]       cnt_q [NUM_BP];
  bpt_ctrl_t              ctrl_q [NUM_BP];

  always_comb begin
    armed_x = '0;
    armed_x[NUM_BP-1:0] = armed_q;
  end

  for (genvar i = 0; i < NUM_BP; i++) begin : g_slot
    logic sel;
    assign sel = cfg_we && !glob && (idx == 4'(i));

    bpt_slot #(.ADDR_W(ADDR_W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmp_we   (sel && (fld == FLD_CMP)),
      .ctrl_we  (sel && (fld == FLD_CTRL)),
      .cmp_wd   (cfg_wdata[ADDR_W-1:0]),
      .ctrl_wd  (ctrl_wd),
      .ia_valid (ia_valid),
      .ia_addr  (ia_addr),
      .da_valid (da_valid),
      .da_addr  (da_addr),
      .cmp_q    (cmp_q[i]),
      .ctrl_q   (ctrl_q[i]),
      .match    (raw_match[i])
    );

    assign chain_on[i]        = ctrl_q[i].chain_en;
    assign pred_flat[4*i +: 4] = ctrl_q[i].pred;
    assign act_v[i]           = ctrl_q[i].act;
    // out-of-range predecessors read a zero in armed_x
    assign fire[i] = raw_match[i] && mask_q[i] &&
                     (!chain_on[i] || armed_x[pred_flat[4*i +: 4]]);

    bpt_sat_cnt #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (sel && (fld == FLD_CNT)),
      .inc   (fire[i]),
      .cnt   (cnt_q[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      armed_q <= '0;
      hit_q   <= '0;
    end else begin
      if (cfg_we && glob && (fld == FLD_MASK)) mask_q <= cfg_wdata[NUM_BP-1:0];
      armed_q <= dbg_reset ? '0 : (armed_q | fire);
      hit_q   <= fire;
    end
  end

  bpt_action #(.NUM_BP(NUM_BP)) u_act (
    .clk       (clk),
    .rst_n     (rst_n),
    .dbg_reset (dbg_reset),
    .fire      (fire),
    .act       (act_v),
    .halt_req  (halt_req),
    .trace_en  (trace_en)
  );

  always_comb begin
    cfg_rdata = '0;
    if (glob) begin
      if (fld == FLD_MASK) cfg_rdata[NUM_BP-1:0] = mask_q;
    end else begin
      for (int i = 0; i < NUM_BP; i++) begin
        if (idx == 4'(i)) begin
          case (fld)
            FLD_CMP:  cfg_rdata[ADDR_W-1:0] = cmp_q[i];
            FLD_CTRL: cfg_rdata[8:0] = {ctrl_q[i].chain_en, ctrl_q[i].pred,
                                        1'b0, ctrl_q[i].dsel, ctrl_q[i].act};
            FLD_CNT:  cfg_rdata[CNT_W-1:0] = cnt_q[i];
            default:  ;
          endcase
        end
      end
    end
  end

  assign bp_hit = hit_q;
endmodule

// File: rtl/bpt_unit_chk.sv
module bpt_unit_chk #(
  parameter int NUM_BP = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                dbg_reset,
  input logic                ia_valid,
  input logic                da_valid,
  input logic                halt_req,
  input logic                trace_en,
  input logic [NUM_BP-1:0]   bp_hit,
  input logic [NUM_BP-1:0]   mask,
  input logic [NUM_BP-1:0]   chain_on,
  input logic [4*NUM_BP-1:0] pred_flat,
  input logic [15:0]         armed_x
);
  p_hit_needs_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|bp_hit) |-> $past(ia_valid || da_valid));

  p_halt_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req && !dbg_reset) |=> halt_req);

  p_halt_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halt_req) |-> (|bp_hit));

  p_trace_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trace_en) |-> (|bp_hit));

  p_dbg_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_reset |=> (!halt_req && !trace_en && (armed_x == 16'h0)));

  for (genvar i = 0; i < NUM_BP; i++) begin : g_chk
    p_mask_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
      bp_hit[i] |-> $past(mask[i]));

    p_chain_armed_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bp_hit[i] && $past(chain_on[i])) |-> $past(armed_x[pred_flat[4*i +: 4]]));
  end
endmodule

bind bpt_unit bpt_unit_chk #(.NUM_BP(NUM_BP)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dbg_reset (dbg_reset),
  .ia_valid  (ia_valid),
  .da_valid  (da_valid),
  .halt_req  (halt_req),
  .trace_en  (trace_en),
  .bp_hit    (bp_hit),
  .mask      (mask_q),
  .chain_on  (chain_on),
  .pred_flat (pred_flat),
  .armed_x   (armed_x)
);

// File: tb/bpt_unit_tb.sv
module bpt_unit_tb;
  localparam int NB = 4;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n, dbg_reset, cfg_we, ia_valid, da_valid;
  logic [7:0]    cfg_addr;
  logic [31:0]   cfg_wdata, cfg_rdata;
  logic [AW-1:0] ia_addr, da_addr;
  logic          halt_req, trace_en;
  logic [NB-1:0] bp_hit;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  bpt_unit #(.NUM_BP(NB), .ADDR_W(AW), .CNT_W(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .dbg_reset(dbg_reset), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .ia_valid(ia_valid), .ia_addr(ia_addr), .da_valid(da_valid),
    .da_addr(da_addr), .halt_req(halt_req), .trace_en(trace_en), .bp_hit(bp_hit)
  );

  typedef struct packed {
    logic        rst;
    logic        we;
    logic [7:0]  addr;
    logic [31:0] wd;
    logic        iv;
    logic [31:0] ia;
    logic        dv;
    logic [31:0] da;
    logic        eh;
    logic        et;
    logic [3:0]  eb;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 23;
  // rst we addr wdata | iv ia | dv da | exp halt trace hit | requirement
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b1,8'h00,32'h100,1'b0,32'h0,  1'b0,32'h0,  1'b0,1'b0,4'h0,8'd2},  // R2 slot0 compare
    '{1'b0,1'b1,8'h01,32'h001,1'b0,32'h0,  1'b0,32'h0,  1'b0,1'b0,4'h0,8'd2},  // R2 slot0 trace start
    '{1'b0,1'b1,8'h08,32'h200,1'b0,32'h0,  1'b0,32'h0,  1'b0,1'b0,4'h0,8'd2},  // R2
    '{1'b0,1'b1,8'h09,32'h002,1'b0,32'h0,  1'b0,32'h0,  1'b0,1'b0,4'h0,8'd2},  // R2 slot1 trace stop
    '{1'b0,1'b1,8'h10,32'h300,1'b0,32'h0,  1'b0,32'h0,  1'b0,1'b0,4'h0,8'd2},  // R2
    '{1'b0,1'b1,8'h11,32'h100,1'b0,32'h0,  1'b0,32'h0,  1'b0,1'b0,4'h0,8'd9},  // R9 slot2 halt chained on slot0
    '{1'b0,1'b1,8'h18,32'h400,1'b0,32'h0,  1'b0,32'h0,  1'b0,1'b0,4'h0,8'd2},  // R2
    '{1'b0,1'b1,8'h19,32'h007,1'b0,32'h0,  1'b0,32'h0,  1'b0,1'b0,4'h0,8'd7},  // R7 slot3 count, data stream
    '{1'b0,1'b0,8'h00,32'h0,  1'b1,32'h100,1'b0,32'h0,  1'b0,1'b0,4'h0,8'd3},  // R3 masked off
    '{1'b0,1'b1,8'h80,32'h00F,1'b0,32'h0,  1'b0,32'h0,  1'b0,1'b0,4'h0,8'd3},  // R3 enable all
    '{1'b0,1'b0,8'h00,32'h0,  1'b1,32'h300,1'b0,32'h0,  1'b0,1'b0,4'h0,8'd9},  // R9 not yet armed
    '{1'b0,1'b0,8'h00,32'h0,  1'b1,32'h100,1'b0,32'h0,  1'b0,1'b1,4'h1,8'd6},  // R6 start
    '{1'b0,1'b0,8'h00,32'h0,  1'b0,32'h0,  1'b0,32'h0,  1'b0,1'b1,4'h0,8'd6},  // R6 hold
    '{1'b0,1'b0,8'h00,32'h0,  1'b1,32'h300,1'b0,32'h0,  1'b1,1'b1,4'h4,8'd9},  // R9 armed, halts
    '{1'b0,1'b0,8'h00,32'h0,  1'b1,32'h200,1'b1,32'h400,1'b1,1'b0,4'hA,8'd6},  // R6 stop + R7 count
    '{1'b0,1'b0,8'h00,32'h0,  1'b1,32'h400,1'b0,32'h0,  1'b1,1'b0,4'h0,8'd4},  // R4 wrong stream
    '{1'b0,1'b0,8'h00,32'h0,  1'b0,32'h0,  1'b1,32'h100,1'b1,1'b0,4'h0,8'd4},  // R4 wrong stream
    '{1'b1,1'b0,8'h00,32'h0,  1'b0,32'h0,  1'b0,32'h0,  1'b0,1'b0,4'h0,8'd10}, // R10 debug reset
    '{1'b0,1'b0,8'h00,32'h0,  1'b1,32'h300,1'b0,32'h0,  1'b0,1'b0,4'h0,8'd10}, // R10 arm cleared
    '{1'b0,1'b1,8'h08,32'h100,1'b0,32'h0,  1'b0,32'h0,  1'b0,1'b0,4'h0,8'd2},  // R2
    '{1'b0,1'b1,8'h09,32'h000,1'b0,32'h0,  1'b0,32'h0,  1'b0,1'b0,4'h0,8'd2},  // R2 slot1 halt
    '{1'b0,1'b0,8'h00,32'h0,  1'b1,32'h100,1'b0,32'h0,  1'b1,1'b1,4'h3,8'd8},  // R8 halt + start
    '{1'b1,1'b0,8'h00,32'h0,  1'b0,32'h0,  1'b0,32'h0,  1'b0,1'b0,4'h0,8'd10}  // R10
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic idle_in();
    dbg_reset = 1'b0; cfg_we = 1'b0; cfg_addr = 8'h0; cfg_wdata = 32'h0;
    ia_valid = 1'b0; ia_addr = '0; da_valid = 1'b0; da_addr = '0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); idle_in();
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #2;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
    @(negedge clk); idle_in();
    cfg_addr = a; #2;
    chk(req, cfg_rdata, exp);
  endtask

  task automatic obs(input logic iv, input logic [31:0] ia, input logic dv, input logic [31:0] da);
    @(negedge clk); idle_in();
    ia_valid = iv; ia_addr = ia; da_valid = dv; da_addr = da;
    @(posedge clk); #2;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    idle_in();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #2;
    // R1 reset state
    chk("R1 outputs", {26'h0, halt_req, trace_en, bp_hit}, 32'h0);
    rd_chk(8'h80, 32'h0, "R1 mask");
    rd_chk(8'h01, 32'h0, "R1 ctrl");

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      dbg_reset = VECS[k].rst; cfg_we = VECS[k].we; cfg_addr = VECS[k].addr;
      cfg_wdata = VECS[k].wd; ia_valid = VECS[k].iv; ia_addr = VECS[k].ia;
      da_valid = VECS[k].dv; da_addr = VECS[k].da;
      @(posedge clk); #2;
      chk($sformatf("R%0d vec %0d", VECS[k].req, k),
          {26'h0, halt_req, trace_en, bp_hit},
          {26'h0, VECS[k].eh, VECS[k].et, VECS[k].eb});
    end

    // R11 counts kept through debug reset (R10), readback R2
    rd_chk(8'h02, 32'd2, "R11 slot0 count");
    rd_chk(8'h0A, 32'd2, "R11 slot1 count");
    rd_chk(8'h12, 32'd1, "R11 slot2 count");
    rd_chk(8'h1A, 32'd1, "R10 slot3 count kept");
    rd_chk(8'h80, 32'hF, "R2 mask readback");
    rd_chk(8'h11, 32'h100, "R2 ctrl readback");
    rd_chk(8'h00, 32'h100, "R2 compare readback");

    // R9 predecessor index out of range never arms
    wr(8'h11, 32'h150);
    obs(1'b1, 32'h300, 1'b0, 32'h0);
    chk("R9 bad predecessor", {28'h0, bp_hit}, 32'h0);

    // R6 stop wins over same-cycle start
    wr(8'h09, 32'h002);
    wr(8'h19, 32'h005);
    obs(1'b0, 32'h0, 1'b1, 32'h400);
    chk("R6 start via data stream", {31'h0, trace_en}, 32'h1);
    obs(1'b1, 32'h100, 1'b0, 32'h0);
    chk("R6 stop wins", {26'h0, halt_req, trace_en, bp_hit}, 32'h03);

    // R11 clear wins over same-cycle hit
    @(negedge clk); idle_in();
    cfg_we = 1'b1; cfg_addr = 8'h02; ia_valid = 1'b1; ia_addr = 32'h100;
    @(posedge clk); #2;
    rd_chk(8'h02, 32'h0, "R11 clear wins");

    // R11 saturation, R7 count-only never halts
    wr(8'h19, 32'h007);
    @(negedge clk); idle_in();
    da_valid = 1'b1; da_addr = 32'h400;
    repeat (65540) @(posedge clk);
    #2;
    rd_chk(8'h1A, 32'hFFFF, "R11 saturate");
    chk("R7 no halt from count", {31'h0, halt_req}, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule